// File: doc/BRIEF.md
# GPIO Pin Interrupt and Configuration-Guard Unit

This block holds the interrupt logic of one general-purpose input port with a parameterised pin count (eight by default). Each pin is brought into the clock domain through a two-flop synchronizer. Per-pin configuration then chooses between edge detection and level detection, between one edge and both edges, and the active polarity. Latched edge events and live level matches form a raw status word. A per-pin enable turns the raw word into a masked word, and the OR of the masked word drives one port interrupt line.

Software reaches the unit through a simple word-addressed register port with a synchronous write strobe and a combinational read. One pin (parameter `PROT_PIN`, pin 0 by default) is special. Its alternate-function, pull-up, pull-down and digital-enable control bits are frozen until two things happen: a 32-bit unlock key is written to the lock register, and then the pin's commit bit is set. The unit only stores the pad control bits and drives them out. It does not build the pads themselves.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register, the raw and masked status and `irq_o` are 0. The lock register reads 1 (locked). The commit register reads all ones except the protected pin's bit, which is 0 (0xFE by default).
- R2: With sense bit 0 (edge) and both-edges bit 0, event bit 1 latches the pin's raw status on a rising synchronized edge and event bit 0 latches it on a falling one. The opposite edge does not latch.
- R3: With sense bit 0 and both-edges bit 1, either edge latches the raw status, whatever the event bit.
- R4: With sense bit 1 (level), the raw status is 1 exactly while the synchronized pin equals the event bit. It is not latched and drops as soon as the level goes away.
- R5: The raw status ignores the mask. The masked status is raw AND mask.
- R6: Writing the acknowledge register clears each latched edge bit where the written data is 1. Bits written 0 are untouched. If a new edge on a bit arrives in the same cycle as its acknowledge, the bit stays set.
- R7: `irq_o` is 1 exactly when any masked status bit is 1.
- R8: The protected pin's alternate-function, pull-up, pull-down and digital-enable bits keep their value on writes while its commit bit is 0. The other pins' bits in those registers are always writable.
- R9: Writing 0x4C4F434B to the lock register unlocks it, and it then reads 0. Writing any other value locks it, and it then reads 1.
- R10: The unprotected pins' commit bits always read 1. The protected pin's commit bit changes only on a commit write while unlocked.
- R11: Suppose a pin changes before clock edge k. A level result shows after edge k+1. An edge result is latched and shows after edge k+2.
- R12: The word addresses are: 0 sense, 1 both-edges, 2 event, 3 mask, 4 raw (read-only), 5 masked (read-only), 6 acknowledge (reads 0), 7 alternate function, 8 pull-up, 9 pull-down, 10 digital enable, 11 lock, 12 commit. Unused addresses read 0. A write takes effect at the clock edge that samples it, and a read returns the current state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Port interrupt, OR of masked status |
| alt_fn_o | output | NUM_PINS | Alternate-function select bits |
| pull_up_o | output | NUM_PINS | Pull-up enable bits |
| pull_dn_o | output | NUM_PINS | Pull-down enable bits |
| dig_en_o | output | NUM_PINS | Digital-enable bits |

## Verification
A register write is sampled at one rising edge and shows on the read port and the pad-control outputs after that edge. A level match shows two edges after a pin change, because it passes through both synchronizer flops. An edge event shows one edge later than that, when the latch captures the comparison against the previous sample, and `irq_o` follows the status in the same cycle. The bench drives inputs 2 ns after a rising edge and compares every output against a behavioural model at the falling edge, so each result is read in the first cycle it is due. The directed checks step one edge at a time across each of these windows, including the case where an acknowledge and a new edge meet.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [REG_AW-1:0] REG_SENSE  = 4'd0;
  localparam logic [REG_AW-1:0] REG_BOTH   = 4'd1;
  localparam logic [REG_AW-1:0] REG_EVENT  = 4'd2;
  localparam logic [REG_AW-1:0] REG_MASK   = 4'd3;
  localparam logic [REG_AW-1:0] REG_RAW    = 4'd4;
  localparam logic [REG_AW-1:0] REG_MASKED = 4'd5;
  localparam logic [REG_AW-1:0] REG_ACK    = 4'd6;
  localparam logic [REG_AW-1:0] REG_ALTFN  = 4'd7;  // guarded block: 7..10
  localparam logic [REG_AW-1:0] REG_PULLUP = 4'd8;
  localparam logic [REG_AW-1:0] REG_PULLDN = 4'd9;
  localparam logic [REG_AW-1:0] REG_DIGEN  = 4'd10;
  localparam logic [REG_AW-1:0] REG_LOCK   = 4'd11;
  localparam logic [REG_AW-1:0] REG_COMMIT = 4'd12;

  localparam int unsigned NUM_GUARDED = 4;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] d_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [STAGES-1:0][NUM_PINS-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] smp_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] raw_o
);
  logic [NUM_PINS-1:0] prev_q, lat_q, edge_ev, level_hit;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall;
    assign rise = smp_i[i] & ~prev_q[i];
    assign fall = ~smp_i[i] & prev_q[i];

    always_comb begin
      if (sense_i[i])     edge_ev[i] = 1'b0;
      else if (both_i[i]) edge_ev[i] = rise | fall;
      else                edge_ev[i] = event_i[i] ? rise : fall;
    end

    assign level_hit[i] = sense_i[i] & ~(smp_i[i] ^ event_i[i]);
    assign raw_o[i]     = sense_i[i] ? level_hit[i] : lat_q[i];

    AST_BOTH_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[i] && both_i[i] && (smp_i[i] != prev_q[i])) |=> (sense_i[i] || raw_o[i])); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[i] && ack_i[i] && (smp_i[i] == prev_q[i])) |=> (sense_i[i] || !raw_o[i])); // R6
    AST_LEVEL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[i] && (smp_i[i] != event_i[i])) |-> !raw_o[i]); // R4
  end

  // new edge overrides a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= smp_i;
      lat_q  <= edge_ev | (lat_q & ~ack_i);
    end
  end
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned PROT_PIN = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] event_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] ack_o,
  output logic [NUM_GUARDED-1:0][NUM_PINS-1:0] guard_o,
  output logic                locked_o,
  output logic [NUM_PINS-1:0] commit_o
);
  logic [NUM_PINS-1:0] sense_q, both_q, event_q, mask_q;
  logic [NUM_GUARDED-1:0][NUM_PINS-1:0] guard_q;
  logic locked_q, commit_q;
  logic [NUM_PINS-1:0] wbits;

  assign wbits = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      mask_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == REG_SENSE) sense_q <= wbits;
      if (addr_i == REG_BOTH)  both_q  <= wbits;
      if (addr_i == REG_EVENT) event_q <= wbits;
      if (addr_i == REG_MASK)  mask_q  <= wbits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      commit_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == REG_LOCK) locked_q <= (wdata_i != UNLOCK_KEY);
      if (addr_i == REG_COMMIT && !locked_q) commit_q <= wdata_i[PROT_PIN];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_commit
    if (i == PROT_PIN) begin : g_prot
      assign commit_o[i] = commit_q;
    end else begin : g_free
      assign commit_o[i] = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_GUARDED; g++) begin : g_guard
    localparam logic [REG_AW-1:0] MY_ADDR = REG_ALTFN + REG_AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) guard_q[g] <= '0;
      else if (wr_en_i && addr_i == MY_ADDR)
        guard_q[g] <= (wbits & commit_o) | (guard_q[g] & ~commit_o);
    end

    AST_PROT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_q |=> $stable(guard_q[g][PROT_PIN])); // R8
  end

  AST_COMMIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(commit_q)); // R10
  AST_KEY_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_LOCK && wdata_i == UNLOCK_KEY) |=> !locked_o); // R9

  assign ack_o    = (wr_en_i && addr_i == REG_ACK) ? wbits : '0;
  assign sense_o  = sense_q;
  assign both_o   = both_q;
  assign event_o  = event_q;
  assign mask_o   = mask_q;
  assign guard_o  = guard_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned PROT_PIN    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] alt_fn_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic [NUM_PINS-1:0] dig_en_o
);
  logic [NUM_PINS-1:0] smp, sense, both, evnt, mask, ack, raw, masked, commit;
  logic [NUM_GUARDED-1:0][NUM_PINS-1:0] guard;
  logic locked;

  gpio_irq_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(smp));

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS), .PROT_PIN(PROT_PIN)) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sense_o(sense), .both_o(both), .event_o(evnt),
    .mask_o(mask), .ack_o(ack), .guard_o(guard), .locked_o(locked),
    .commit_o(commit));

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) i_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .sense_i(sense),
    .both_i(both), .event_i(evnt), .ack_i(ack), .raw_o(raw));

  assign masked = raw & mask;
  assign irq_o  = |masked;

  assign alt_fn_o  = guard[0];
  assign pull_up_o = guard[1];
  assign pull_dn_o = guard[2];
  assign dig_en_o  = guard[3];

  always_comb begin
    unique case (addr_i)
      REG_SENSE:  rdata_o = DATA_W'(sense);
      REG_BOTH:   rdata_o = DATA_W'(both);
      REG_EVENT:  rdata_o = DATA_W'(evnt);
      REG_MASK:   rdata_o = DATA_W'(mask);
      REG_RAW:    rdata_o = DATA_W'(raw);
      REG_MASKED: rdata_o = DATA_W'(masked);
      REG_ALTFN:  rdata_o = DATA_W'(guard[0]);
      REG_PULLUP: rdata_o = DATA_W'(guard[1]);
      REG_PULLDN: rdata_o = DATA_W'(guard[2]);
      REG_DIGEN:  rdata_o = DATA_W'(guard[3]);
      REG_LOCK:   rdata_o = DATA_W'(locked);
      REG_COMMIT: rdata_o = DATA_W'(commit);
      default:    rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R7
endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
  localparam int unsigned NP = 8;
  localparam logic [31:0] KEY = 32'h4C4F_434B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [NP-1:0] alt_fn, pull_up, pull_dn, dig_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_unit i_gpio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .alt_fn_o(alt_fn),
    .pull_up_o(pull_up), .pull_dn_o(pull_dn), .dig_en_o(dig_en));

  // behavioural reference state
  bit [7:0] m_sy1, m_s, m_p, m_lat, m_sense, m_both, m_event, m_mask;
  bit [7:0] m_alt, m_pu, m_pd, m_den;
  bit m_locked, m_commit;

  function automatic bit [7:0] m_raw();
    bit [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m_sense[i] ? (m_s[i] == m_event[i]) : m_lat[i];
    return r;
  endfunction

  function automatic bit [7:0] m_cm();
    return {7'h7f, m_commit};
  endfunction

  function automatic bit [31:0] m_read(input logic [3:0] a);
    case (a)
      0: return {24'd0, m_sense};
      1: return {24'd0, m_both};
      2: return {24'd0, m_event};
      3: return {24'd0, m_mask};
      4: return {24'd0, m_raw()};
      5: return {24'd0, m_raw() & m_mask};
      7: return {24'd0, m_alt};
      8: return {24'd0, m_pu};
      9: return {24'd0, m_pd};
      10: return {24'd0, m_den};
      11: return {31'd0, m_locked};
      12: return {24'd0, m_cm()};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4: return "R2 raw";
      5: return "R5 masked";
      7, 8, 9, 10: return "R8 guarded";
      11: return "R9 lock";
      12: return "R10 commit";
      default: return "R12 regs";
    endcase
  endfunction

  function automatic bit [7:0] guard_upd(input bit [7:0] old, input bit [7:0] d);
    return (d & m_cm()) | (old & ~m_cm());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sy1 = 0; m_s = 0; m_p = 0; m_lat = 0;
      m_sense = 0; m_both = 0; m_event = 0; m_mask = 0;
      m_alt = 0; m_pu = 0; m_pd = 0; m_den = 0;
      m_locked = 1; m_commit = 0;
    end else begin
      bit [7:0] ev, ak;
      for (int i = 0; i < 8; i++) begin
        bit r, f;
        r = m_s[i] && !m_p[i];
        f = !m_s[i] && m_p[i];
        ev[i] = !m_sense[i] && (m_both[i] ? (r || f) : (m_event[i] ? r : f));
      end
      ak = (wr_en && addr == 4'd6) ? wdata[7:0] : 8'd0;
      m_lat = ev | (m_lat & ~ak);
      m_p = m_s; m_s = m_sy1; m_sy1 = pins;
      if (wr_en) begin
        case (addr)
          0: m_sense = wdata[7:0];
          1: m_both = wdata[7:0];
          2: m_event = wdata[7:0];
          3: m_mask = wdata[7:0];
          7: m_alt = guard_upd(m_alt, wdata[7:0]);
          8: m_pu = guard_upd(m_pu, wdata[7:0]);
          9: m_pd = guard_upd(m_pd, wdata[7:0]);
          10: m_den = guard_upd(m_den, wdata[7:0]);
          11: begin
            if (!m_locked || 1'b1) ; // commit decision below uses old lock
          end
          default: ;
        endcase
        if (addr == 4'd12 && !m_locked) m_commit = wdata[0];
        if (addr == 4'd11) m_locked = (wdata != KEY);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 irq", {31'd0, irq}, {31'd0, |(m_raw() & m_mask)});
      chk("R8 alt_fn", {24'd0, alt_fn}, {24'd0, m_alt});
      chk("R8 pull_up", {24'd0, pull_up}, {24'd0, m_pu});
      chk("R8 pull_dn", {24'd0, pull_dn}, {24'd0, m_pd});
      chk("R8 dig_en", {24'd0, dig_en}, {24'd0, m_den});
      chk(tag_of(addr), rdata, m_read(addr));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    @(posedge clk); #2;
  endtask

  task automatic look(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    look(4'd11, 32'd1, "R1 lock after reset");
    look(4'd12, 32'hFE, "R1 commit after reset");
    look(4'd4, 32'd0, "R1 raw after reset");
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    step(1);

    // R2 / R11 rising edge on pin1
    wr(4'd3, 32'hFF);
    wr(4'd2, 32'h02);
    pins[1] = 1'b1;
    look(4'd4, 32'h00, "R11 raw before edge k");
    step(1); look(4'd4, 32'h00, "R11 raw after k");
    step(1); look(4'd4, 32'h00, "R11 raw after k+1");
    step(1); look(4'd4, 32'h02, "R11 R2 raw after k+2");
    chk("R7 irq on edge", {31'd0, irq}, 32'd1);
    step(1);

    // R2 falling edge on pin2, rising ignored
    pins[2] = 1'b1; step(4);
    look(4'd4, 32'h02, "R2 rising ignored when falling selected");
    step(1);
    pins[2] = 1'b0; step(3);
    look(4'd4, 32'h06, "R2 falling latched");
    step(1);

    // R6 acknowledge
    wr(4'd6, 32'h00);
    look(4'd4, 32'h06, "R6 ack of zeros no effect");
    step(1);
    wr(4'd6, 32'h02);
    look(4'd4, 32'h04, "R6 ack clears bit1");
    step(1);

    // R3 both edges on pin3
    wr(4'd1, 32'h08);
    pins[3] = 1'b1; step(3);
    look(4'd4, 32'h0C, "R3 rising with both edges");
    step(1);
    // R6 edge and ack on the same edge
    pins[3] = 1'b0; step(2);
    wr_en = 1'b1; addr = 4'd6; wdata = 32'h08;
    step(1);
    wr_en = 1'b0;
    look(4'd4, 32'h0C, "R6 same-cycle edge wins over ack");
    step(1);
    wr(4'd6, 32'h0C);
    look(4'd4, 32'h00, "R6 ack clears bits 2 and 3");
    chk("R7 irq low when status clear", {31'd0, irq}, 32'd0);
    step(1);

    // R4 level sense on pin4
    wr(4'd0, 32'h10);
    wr(4'd2, 32'h12);
    pins[4] = 1'b1;
    step(1); look(4'd4, 32'h00, "R11 level after k");
    step(1); look(4'd4, 32'h10, "R4 R11 level after k+1");
    step(1);
    pins[4] = 1'b0; step(2);
    look(4'd4, 32'h00, "R4 level not latched");
    step(1);
    wr(4'd2, 32'h02);
    look(4'd4, 32'h10, "R4 low-level polarity");
    step(1);

    // R5 mask
    wr(4'd3, 32'h00);
    look(4'd5, 32'h00, "R5 masked zero");
    chk("R7 irq masked off", {31'd0, irq}, 32'd0);
    step(1);
    look(4'd4, 32'h10, "R5 raw ignores mask");
    step(1);
    wr(4'd3, 32'h10);
    look(4'd5, 32'h10, "R5 masked follows raw");
    chk("R7 irq with enabled bit", {31'd0, irq}, 32'd1);
    step(1);

    // R8 R9 R10 lock and commit
    wr(4'd8, 32'hFF);
    look(4'd8, 32'hFE, "R8 protected pull-up frozen while locked");
    step(1);
    wr(4'd10, 32'hFF);
    chk("R8 dig_en port", {24'd0, dig_en}, 32'hFE);
    wr(4'd12, 32'hFF);
    look(4'd12, 32'hFE, "R10 commit frozen while locked");
    step(1);
    wr(4'd11, KEY);
    look(4'd11, 32'd0, "R9 key unlocks");
    step(1);
    wr(4'd12, 32'h01);
    look(4'd12, 32'hFF, "R10 commit set while unlocked");
    step(1);
    wr(4'd8, 32'hFF);
    look(4'd8, 32'hFF, "R8 protected bit writable after commit");
    step(1);
    wr(4'd11, 32'h1234);
    look(4'd11, 32'd1, "R9 other value relocks");
    step(1);
    wr(4'd12, 32'h00);
    look(4'd12, 32'hFF, "R10 commit clear ignored while locked");
    step(1);
    wr(4'd8, 32'h00);
    look(4'd8, 32'h00, "R8 still writable while committed");
    step(1);
    wr(4'd11, KEY);
    wr(4'd12, 32'h00);
    wr(4'd11, 32'h0);
    wr(4'd8, 32'h01);
    look(4'd8, 32'h00, "R8 frozen again after commit cleared");
    step(1);

    // random traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      pins = NP'($urandom);
      if (($urandom % 10) < 3) begin
        wr_en = 1'b1;
        addr = 4'($urandom % 14);
        wdata = (addr == 4'd11 && ($urandom % 2) == 0) ? KEY : $urandom;
      end else begin
        wr_en = 1'b0;
        addr = 4'($urandom % 14);
      end
      step(1);
    end
    wr_en = 1'b0;
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule